// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves data between a peripheral FIFO at a fixed address and memory. It alternates between two memory buffers. Each buffer has its own current address and its own remaining-transfer count. Software controls the channel through a 32-bit register bus. The control word is reached through two write ports. One port ORs bits in and the other knocks bits out, so enabling a buffer or acknowledging a done flag never needs a read-modify-write.

While GO is set, the channel issues one memory beat at a time for the active buffer, each beat gated by the peripheral's request line. Every beat advances that buffer's address by the device width and lowers its count by one. When a buffer runs out, the channel:

- raises that buffer's done flag;
- drops that buffer's enable;
- moves to the other buffer as soon as that buffer is enabled.

Software keeps the pipeline full by refilling and re-enabling the idle buffer. A halt status bit tells software when a removed GO has taken effect.

Top module: `dbdma_channel`

## Requirements
- R1: A register write at offset 0x00 ORs the write data into the control word, and a write at 0x04 clears every control bit that is 1 in the write data. Bits 6 and 14 and bits 31:24 are not writable. A read at 0x00 returns the control word, with bit 6 carrying the halt status. Control bit positions: 0 enable buffer 0, 1 buffer 0 done, 2 enable buffer 1, 3 buffer 1 done, 4 active buffer, 5 GO, 7 interrupt enable, 10:9 width code, 12 direction, 23:20 peripheral high address.
- R2: Offsets 0x08 (peripheral address), 0x0C and 0x14 (buffer 0 and buffer 1 address) and 0x10 and 0x18 (buffer 0 and buffer 1 count) are written and read back. A count register holds the count in bits 15:0 and that buffer's high address in bits 19:16, and reads 0 in bits 31:20.
- R3: A beat starts only when all of these hold: GO is 1, the active buffer is enabled, its count is non-zero, dev_req is high and no beat is outstanding. mem_req then stays high until the cycle in which mem_ack is seen, and no beat is started while dev_req is low.
- R4: During a beat, mem_addr is the active buffer's high bits above its current address. mem_size is the width code and mem_write is control bit 12. dev_addr is control bits 23:20 above the peripheral address register.
- R5: Each acknowledged beat lowers the active count by one and raises the active address by 1, 2 or 4 for width codes 0, 1 or 2.
- R6: The acknowledge of a buffer's last beat sets that buffer's done bit and clears its enable bit at the same clock edge. An enabled active buffer whose count is already zero completes in the same way without any beat while GO is 1.
- R7: While GO is 1 and no beat is outstanding, an active buffer that is not enabled hands over to the other buffer if that buffer is enabled, and bit 4 toggles. Otherwise bit 4 holds and the channel waits with GO still set.
- R8: Halt (bit 6) reads 1 when GO is 0 and no beat is outstanding. Clearing GO during a beat lets that beat finish, with halt reading 0 until its acknowledge. No further beat starts afterwards.
- R9: irq is high exactly when interrupt enable is set and at least one done bit is set.
- R10: residue equals the active buffer's count shifted left by 0, 1 or 2 for width codes 0, 1 or 2.
- R11: When a hardware completion and a software write to the control word fall on the same edge, hardware wins. A clear of the finishing buffer's done bit is lost, and a set of its enable bit is lost.
- R12: After reset all registers are zero. Offset 0x00 therefore reads 0x40, and mem_req, irq and residue are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dev_req | input | 1 | Peripheral ready for a transfer |
| dev_addr | output | 36 | Peripheral FIFO address |
| mem_req | output | 1 | Memory beat outstanding |
| mem_ack | input | 1 | Memory beat accepted |
| mem_addr | output | 36 | Memory address of the current beat |
| mem_size | output | 2 | Beat width code |
| mem_write | output | 1 | 1 when the beat writes memory |
| irq | output | 1 | Buffer-done interrupt |
| residue | output | 18 | Remaining bytes in the active buffer |

## Verification
The clash that matters is a buffer finishing on the exact edge on which software writes the control word. At that edge the hardware sets the done bit and drops the enable. The bench makes this happen by raising the set or clear write strobe in the same cycle as the acknowledge of a one-beat buffer. Afterwards it reads the control word back and expects the hardware result to have survived the software write. The hand-over to the next buffer, one edge after a completion, is judged separately: the bench watches the beat address sequence and the active-buffer bit, under a randomly gated peripheral request and acknowledge.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

    // control word bit positions
    localparam int B_EN0  = 0;
    localparam int B_DN0  = 1;
    localparam int B_EN1  = 2;
    localparam int B_DN1  = 3;
    localparam int B_ACT  = 4;
    localparam int B_GO   = 5;
    localparam int B_HALT = 6;
    localparam int B_IE   = 7;
    localparam int B_WID  = 9;
    localparam int B_DIR  = 12;
    localparam int B_PHI  = 20;

    localparam logic [31:0] CTRL_WMASK = 32'h00FF_BFBF;

    // register offsets
    localparam int OFS_SET  = 'h00;
    localparam int OFS_CLR  = 'h04;
    localparam int OFS_PER  = 'h08;
    localparam int OFS_A0   = 'h0C;
    localparam int OFS_C0   = 'h10;
    localparam int OFS_A1   = 'h14;
    localparam int OFS_C1   = 'h18;

    typedef struct packed {
        logic cmpl;      // a buffer finished
        logic cmpl_buf;  // which one
        logic swap;      // toggle the active buffer
    } hw_evt_t;

    function automatic logic [1:0] width_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dbdma_ctrlreg.sv
module dbdma_ctrlreg
    import dbdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  hw_evt_t     evt,
    output logic [31:0] ctrl_q
);

    logic [31:0] ctrl_n;

    always_comb begin
        ctrl_n = ctrl_q;
        if (set_we) ctrl_n = ctrl_n | (wdata & CTRL_WMASK);
        if (clr_we) ctrl_n = ctrl_n & ~(wdata & CTRL_WMASK);
        // hardware events applied last so they win a collision
        if (evt.cmpl) begin
            if (evt.cmpl_buf) begin
                ctrl_n[B_DN1] = 1'b1;
                ctrl_n[B_EN1] = 1'b0;
            end else begin
                ctrl_n[B_DN0] = 1'b1;
                ctrl_n[B_EN0] = 1'b0;
            end
        end
        if (evt.swap) ctrl_n[B_ACT] = ~ctrl_q[B_ACT];
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_n;
    end

    // R11: completion of buffer 0 survives any same-cycle software write
    p_cmpl0_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (evt.cmpl && !evt.cmpl_buf) |=> (ctrl_q[B_DN0] && !ctrl_q[B_EN0]));
    p_cmpl1_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (evt.cmpl && evt.cmpl_buf) |=> (ctrl_q[B_DN1] && !ctrl_q[B_EN1]));
    // R7: a swap flips the active-buffer bit
    p_swap_flips_r7: assert property (@(posedge clk) disable iff (rst)
        evt.swap |=> (ctrl_q[B_ACT] != $past(ctrl_q[B_ACT])));

endmodule

// File: rtl/dbdma_bufregs.sv
module dbdma_bufregs #(
    parameter int NBUF   = 2,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 4,
    localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NBUF-1:0]             addr_we,
    input  logic [NBUF-1:0]             cnt_we,
    input  logic [31:0]                 wdata,
    input  logic                        adv,
    input  logic [SEL_W-1:0]            adv_sel,
    input  logic [2:0]                  step,
    output logic [NBUF-1:0][ADDR_W-1:0] addr_q,
    output logic [NBUF-1:0][CNT_W-1:0]  cnt_q,
    output logic [NBUF-1:0][HI_W-1:0]   hi_q
);

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic hit;
        assign hit = adv && (adv_sel == SEL_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_q[b] <= '0;
                cnt_q[b]  <= '0;
                hi_q[b]   <= '0;
            end else begin
                if (addr_we[b])  addr_q[b] <= wdata[ADDR_W-1:0];
                else if (hit)    addr_q[b] <= addr_q[b] + ADDR_W'(step);
                if (cnt_we[b]) begin
                    cnt_q[b] <= wdata[CNT_W-1:0];
                    hi_q[b]  <= wdata[CNT_W +: HI_W];
                end else if (hit) begin
                    cnt_q[b] <= cnt_q[b] - CNT_W'(1);
                end
            end
        end

        // R5: an acknowledged beat lowers the count by one
        p_cnt_dec_r5: assert property (@(posedge clk) disable iff (rst)
            (hit && !cnt_we[b]) |=> (cnt_q[b] == $past(cnt_q[b]) - CNT_W'(1)));
        // R5: an acknowledged beat raises the address by the step
        p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
            (hit && !addr_we[b]) |=> (addr_q[b] == $past(addr_q[b]) + ADDR_W'($past(step))));
    end

endmodule

// File: rtl/dbdma_engine.sv
module dbdma_engine
    import dbdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       act,
    input  logic [1:0] en,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  logic       dev_req,
    input  logic       mem_ack,
    output logic       busy,
    output logic       adv,
    output hw_evt_t    evt
);

    logic issue;

    assign issue = go && en[act] && !cnt_zero && dev_req && !busy;
    assign adv   = busy && mem_ack;

    always_comb begin
        evt.cmpl     = (adv && cnt_one) || (go && en[act] && cnt_zero && !busy);
        evt.cmpl_buf = act;
        evt.swap     = go && !busy && !en[act] && en[~act];
    end

    always_ff @(posedge clk) begin
        if (rst)          busy <= 1'b0;
        else if (issue)   busy <= 1'b1;
        else if (mem_ack) busy <= 1'b0;
    end

    // R3: a beat stays requested until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> busy);
    // R3: a beat only starts with the peripheral requesting and GO set
    p_issue_gated_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(dev_req) && $past(go)));

endmodule

// File: rtl/dbdma_channel.sv
module dbdma_channel
    import dbdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 4,
    parameter int RA_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 dev_req,
    output logic [HI_W+ADDR_W-1:0] dev_addr,
    output logic                 mem_req,
    input  logic                 mem_ack,
    output logic [HI_W+ADDR_W-1:0] mem_addr,
    output logic [1:0]           mem_size,
    output logic                 mem_write,
    output logic                 irq,
    output logic [CNT_W+1:0]     residue
);

    localparam int NBUF  = 2;
    localparam int RES_W = CNT_W + 2;

    logic [31:0]                 ctrl_q;
    logic [31:0]                 ctrl_rd;
    logic [ADDR_W-1:0]           per_q;
    logic [NBUF-1:0][ADDR_W-1:0] addr_q;
    logic [NBUF-1:0][CNT_W-1:0]  cnt_q;
    logic [NBUF-1:0][HI_W-1:0]   hi_q;
    logic                        set_we, clr_we, per_we;
    logic [NBUF-1:0]             addr_we, cnt_we;
    logic                        busy, adv, halt, act;
    logic [1:0]                  shamt;
    logic [2:0]                  step;
    hw_evt_t                     evt;

    // register decode
    assign set_we     = reg_wr && (reg_addr == RA_W'(OFS_SET));
    assign clr_we     = reg_wr && (reg_addr == RA_W'(OFS_CLR));
    assign per_we     = reg_wr && (reg_addr == RA_W'(OFS_PER));
    assign addr_we[0] = reg_wr && (reg_addr == RA_W'(OFS_A0));
    assign addr_we[1] = reg_wr && (reg_addr == RA_W'(OFS_A1));
    assign cnt_we[0]  = reg_wr && (reg_addr == RA_W'(OFS_C0));
    assign cnt_we[1]  = reg_wr && (reg_addr == RA_W'(OFS_C1));

    always_ff @(posedge clk) begin
        if (rst)         per_q <= '0;
        else if (per_we) per_q <= reg_wdata[ADDR_W-1:0];
    end

    dbdma_ctrlreg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .set_we (set_we),
        .clr_we (clr_we),
        .wdata  (reg_wdata),
        .evt    (evt),
        .ctrl_q (ctrl_q)
    );

    assign act   = ctrl_q[B_ACT];
    assign shamt = width_shift(ctrl_q[B_WID +: 2]);
    assign step  = 3'd1 << shamt;

    dbdma_bufregs #(
        .NBUF   (NBUF),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .HI_W   (HI_W)
    ) u_bufs (
        .clk     (clk),
        .rst     (rst),
        .addr_we (addr_we),
        .cnt_we  (cnt_we),
        .wdata   (reg_wdata),
        .adv     (adv),
        .adv_sel (act),
        .step    (step),
        .addr_q  (addr_q),
        .cnt_q   (cnt_q),
        .hi_q    (hi_q)
    );

    dbdma_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (ctrl_q[B_GO]),
        .act      (act),
        .en       ({ctrl_q[B_EN1], ctrl_q[B_EN0]}),
        .cnt_zero (cnt_q[act] == '0),
        .cnt_one  (cnt_q[act] == CNT_W'(1)),
        .dev_req  (dev_req),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .adv      (adv),
        .evt      (evt)
    );

    assign halt = !ctrl_q[B_GO] && !busy;

    always_comb begin
        ctrl_rd         = ctrl_q;
        ctrl_rd[B_HALT] = halt;
    end

    function automatic logic [31:0] pack_cnt(input logic [CNT_W-1:0] c,
                                             input logic [HI_W-1:0] h);
        logic [31:0] r;
        r = '0;
        r[CNT_W-1:0]     = c;
        r[CNT_W +: HI_W] = h;
        return r;
    endfunction

    always_comb begin
        case (reg_addr)
            RA_W'(OFS_SET): reg_rdata = ctrl_rd;
            RA_W'(OFS_PER): reg_rdata = 32'(per_q);
            RA_W'(OFS_A0):  reg_rdata = 32'(addr_q[0]);
            RA_W'(OFS_C0):  reg_rdata = pack_cnt(cnt_q[0], hi_q[0]);
            RA_W'(OFS_A1):  reg_rdata = 32'(addr_q[1]);
            RA_W'(OFS_C1):  reg_rdata = pack_cnt(cnt_q[1], hi_q[1]);
            default:        reg_rdata = '0;
        endcase
    end

    assign dev_addr  = {ctrl_q[B_PHI +: HI_W], per_q};
    assign mem_req   = busy;
    assign mem_addr  = {hi_q[act], addr_q[act]};
    assign mem_size  = ctrl_q[B_WID +: 2];
    assign mem_write = ctrl_q[B_DIR];
    assign irq       = ctrl_q[B_IE] && (ctrl_q[B_DN0] || ctrl_q[B_DN1]);
    assign residue   = RES_W'(cnt_q[act]) << shamt;

    // R4: the beat address does not move while waiting for the acknowledge
    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !reg_wr) |=> $stable(mem_addr));
    // R8: halt never reads 1 while a beat is outstanding
    p_no_halt_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ctrl_rd[B_HALT]);
    // R9: the interrupt needs its enable
    p_irq_enable_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q[B_IE]);

endmodule

// File: tb/dbdma_channel_test.sv
module dbdma_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic [35:0] dev_addr;
    logic        mem_req;
    logic        mem_ack = 1'b0;
    logic [35:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_write;
    logic        irq;
    logic [17:0] residue;

    int nchk = 0;
    int nfail = 0;
    bit auto_ack = 1'b0;
    bit rand_req = 1'b0;
    logic [1:0] exp_w = 2'd0;
    logic       exp_dir = 1'b0;
    logic [35:0] blog [0:63];
    int nbeat = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbdma_channel uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .dev_addr(dev_addr), .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_write(mem_write),
        .irq(irq), .residue(residue)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        wr(8'h04, 32'hFFFF_FFFF);
        exp_w = 2'd0; exp_dir = 1'b0;
    endtask

    task automatic wait_bits(input logic [31:0] mask, input string req);
        logic [31:0] m;
        int n = 0;
        do begin
            rd(8'h00, m);
            n++;
        end while (((m & mask) != mask) && n < 3000);
        chk(req, "wait for done bits", 64'(m & mask), 64'(mask));
    endtask

    task automatic wait_req();
        int n = 0;
        while (!mem_req && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // memory responder: random acknowledge delay, logs beat addresses
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack) begin
                if (mem_req && !mem_ack && ($urandom % 3 != 0)) begin
                    if (nbeat < 64) blog[nbeat] = mem_addr;
                    nbeat++;
                    chk("R4", "mem_size", 64'(mem_size), 64'(exp_w));
                    chk("R4", "mem_write", 64'(mem_write), 64'(exp_dir));
                    mem_ack = 1'b1;
                end else begin
                    mem_ack = 1'b0;
                end
            end
        end
    end

    // peripheral request: random gating when enabled
    initial begin
        forever begin
            @(negedge clk);
            if (rand_req) dev_req = ($urandom % 4 != 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] m;
        logic [31:0] d;
        int seed;
        seed = $urandom(32'd20240611);

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(8'h00, m);
        chk("R12", "ctrl after reset", 64'(m), 64'h40);
        rd(8'h10, d);
        chk("R12", "count0 after reset", 64'(d), 64'h0);
        chk("R12", "mem_req after reset", 64'(mem_req), 64'h0);
        chk("R12", "irq after reset", 64'(irq), 64'h0);
        chk("R12", "residue after reset", 64'(residue), 64'h0);

        // R1 set/clear ports and reserved bits (no enables or GO)
        wr(8'h00, 32'hFFFF_FFDA);
        rd(8'h00, m);
        chk("R1", "ctrl after set", 64'(m), 64'h00FF_BFDA);
        wr(8'h04, 32'h0000_FF00);
        rd(8'h00, m);
        chk("R1", "ctrl after clear", 64'(m), 64'h00FF_00DA);

        // R4 peripheral address composition (bits 23:20 = A from above)
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h04, 32'h0050_0000);
        @(negedge clk);
        chk("R4", "dev_addr", 64'(dev_addr), 64'hA_DEAD_BEEF);
        clear_all();
        rd(8'h00, m);
        chk("R1", "ctrl after clear all", 64'(m), 64'h40);

        // R2 register readback
        rd(8'h08, d);
        chk("R2", "peripheral address", 64'(d), 64'hDEAD_BEEF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d);
        chk("R2", "count0 format", 64'(d), 64'h000F_FFFF);
        wr(8'h14, 32'h1234_5678);
        rd(8'h14, d);
        chk("R2", "address1", 64'(d), 64'h1234_5678);

        // R10 residue scaling
        wr(8'h10, 32'd5);
        wr(8'h00, 32'h0000_0200);
        @(negedge clk);
        chk("R10", "residue width 16", 64'(residue), 64'd10);
        wr(8'h18, 32'd7);
        wr(8'h04, 32'h0000_0600);
        wr(8'h00, 32'h0000_0410);
        @(negedge clk);
        chk("R10", "residue width 32 buffer 1", 64'(residue), 64'd28);
        clear_all();

        // R6 empty buffer completes without a beat
        wr(8'h10, 32'd0);
        wr(8'h00, 32'h21);
        rd(8'h00, m);
        chk("R6", "empty buffer done", 64'(m & 32'h3), 64'h2);
        chk("R6", "no beat for empty buffer", 64'(mem_req), 64'h0);
        clear_all();

        // R8 / R3 halt handshake and request gating, manual acknowledge
        dev_req = 1'b1;
        wr(8'h0C, 32'h0000_1000);
        wr(8'h10, 32'd4);
        wr(8'h00, 32'h21);
        wait_req();
        chk("R3", "beat started", 64'(mem_req), 64'h1);
        wr(8'h04, 32'h20);
        chk("R8", "beat held after GO cleared", 64'(mem_req), 64'h1);
        rd(8'h00, m);
        chk("R8", "halt low with beat outstanding", 64'(m[6]), 64'h0);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R8", "beat ended", 64'(mem_req), 64'h0);
        rd(8'h00, m);
        chk("R8", "halt high after ack", 64'(m[6]), 64'h1);
        rd(8'h10, d);
        chk("R5", "count after one beat", 64'(d), 64'd3);
        rd(8'h0C, d);
        chk("R5", "address after one beat", 64'(d), 64'h1001);
        repeat (4) @(negedge clk);
        chk("R8", "no beat after halt", 64'(mem_req), 64'h0);
        dev_req = 1'b0;
        wr(8'h00, 32'h20);
        repeat (5) @(negedge clk);
        chk("R3", "no beat without dev_req", 64'(mem_req), 64'h0);
        dev_req = 1'b1;
        @(negedge clk);
        chk("R3", "beat once dev_req high", 64'(mem_req), 64'h1);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        clear_all();

        // R11 collision: clear of done0 on the completing edge
        wr(8'h10, 32'd1);
        wr(8'h00, 32'h21);
        wait_req();
        mem_ack = 1'b1; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h2;
        @(negedge clk);
        mem_ack = 1'b0; reg_wr = 1'b0;
        rd(8'h00, m);
        chk("R11", "done0 survives clear", 64'(m & 32'h3), 64'h2);

        // R9 interrupt
        chk("R9", "irq off without enable", 64'(irq), 64'h0);
        wr(8'h00, 32'h80);
        chk("R9", "irq on with done", 64'(irq), 64'h1);
        wr(8'h04, 32'h2);
        chk("R9", "irq off after done cleared", 64'(irq), 64'h0);
        clear_all();

        // R11 collision: set of en0 on the completing edge
        wr(8'h10, 32'd1);
        wr(8'h00, 32'h21);
        wait_req();
        mem_ack = 1'b1; reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h1;
        @(negedge clk);
        mem_ack = 1'b0; reg_wr = 1'b0;
        rd(8'h00, m);
        chk("R11", "en0 cleared despite set", 64'(m & 32'h3), 64'h2);
        clear_all();

        // R7 wait for the second buffer, then hand over
        auto_ack = 1'b1;
        nbeat = 0;
        wr(8'h0C, 32'h2000); wr(8'h10, 32'd2);
        wr(8'h14, 32'h3000); wr(8'h18, 32'd1);
        wr(8'h00, 32'h21);
        wait_bits(32'h2, "R6");
        repeat (4) @(negedge clk);
        rd(8'h00, m);
        chk("R7", "no switch while buffer 1 disabled", 64'(m & 32'h70), 64'h20);
        wr(8'h00, 32'h4);
        wait_bits(32'h8, "R6");
        rd(8'h00, m);
        chk("R7", "switched to buffer 1", 64'(m[4]), 64'h1);
        chk("R7", "beats across hand-over", 64'(nbeat), 64'd3);
        chk("R4", "beat address buffer 1", 64'(blog[2]), 64'h0_0000_3000);
        clear_all();

        // random ping-pong trials (R3 R4 R5 R6 R7)
        rand_req = 1'b1;
        for (int t = 0; t < 12; t++) begin
            logic [1:0]  w;
            logic        dir;
            logic [3:0]  h0, h1;
            logic [31:0] s0, s1;
            int c0, c1, stp;
            w   = 2'($urandom % 3);
            dir = 1'($urandom % 2);
            h0  = 4'($urandom); h1 = 4'($urandom);
            s0  = $urandom; s1 = $urandom;
            c0  = 1 + ($urandom % 8); c1 = 1 + ($urandom % 8);
            stp = 1 << w;
            clear_all();
            exp_w = w; exp_dir = dir;
            nbeat = 0;
            wr(8'h0C, s0); wr(8'h10, {12'h0, h0, 16'(c0)});
            wr(8'h14, s1); wr(8'h18, {12'h0, h1, 16'(c1)});
            wr(8'h00, 32'h25 | (32'(w) << 9) | (32'(dir) << 12));
            wait_bits(32'hA, "R6");
            rd(8'h00, m);
            chk("R7", "ctrl after both buffers",
                64'(m), 64'(32'h3A | (32'(w) << 9) | (32'(dir) << 12)));
            chk("R3", "beat count", 64'(nbeat), 64'(c0 + c1));
            for (int i = 0; i < c0 + c1; i++) begin
                logic [35:0] e;
                if (i < c0) e = {h0, s0 + 32'(i * stp)};
                else        e = {h1, s1 + 32'((i - c0) * stp)};
                chk("R5", "beat address", 64'(blog[i]), 64'(e));
            end
            rd(8'h0C, d);
            chk("R5", "final address0", 64'(d), 64'(s0 + 32'(c0 * stp)));
            rd(8'h18, d);
            chk("R2", "final count1", 64'(d), 64'({12'h0, h1, 16'h0}));
        end
        rand_req = 1'b0;
        clear_all();
        rd(8'h00, m);
        chk("R8", "halt after GO cleared", 64'(m[6]), 64'h1);

        finish_up();
    end

endmodule